// File: doc/BRIEF.md
# Link Rate Negotiation Controller

This controller sequences bring-up of a serial camera link toward an external transceiver wrapper. After reset it always starts at the base (10G) rate. It holds the downstream PLL in reset for a fixed settle time and then waits for the transceiver to report link-up. Once the link is up and a command channel is reported ready, it requests a read of the peer's capability. It chooses the high (25G) rate only when the peer reports high-rate support and the local side also supports it.

To change rate, the controller requests a link drop, switches the rate select and holds the PLL in reset for the settle time. It then trains at 25G. If the link does not come up within a parameterized timeout, it drops the link again, returns to 10G and retrains. After such a fallback, or after a negative capability answer, it attempts no upgrade until the next reset. A loss of link-up while linked returns the controller to training at the rate it was using. A status output gives the rate of the established link, and a one-cycle pulse marks each link-up.

Top module: `link_rate_ctrl`

## Requirements
- R1: Asynchronous reset drives rate_sel_o=0, link_drop_o=0, pll_rst_o=1, cap_req_o=0, rate_status_o=00 and up_pulse_o=0. After reset release (2 synchroniser cycles), pll_rst_o stays 1 for PLL_WAIT more cycles and then falls, with training at 10G.
- R2: While training at 10G, link_up_i=1 sampled on an edge gives rate_status_o=01 (linked at 10G) and up_pulse_o=1 after that edge. The pulse lasts exactly one cycle.
- R3: cap_req_o rises on the edge after cmd_ready_i=1 is sampled while linked at 10G. It stays high until cap_valid_i=1 or link_up_i=0 is sampled. Loss of link returns to 10G training with rate_status_o=00.
- R4: When cap_valid_i=1 arrives with peer_cap_i=0 or local_cap_i=0, the link stays at 10G (rate_status_o=01) and cap_req_o falls. cap_req_o is not raised again before the next reset.
- R5: When cap_valid_i=1 arrives with peer_cap_i=1 and local_cap_i=1, link_drop_o, pll_rst_o and rate_sel_o are all 1 for PLL_WAIT cycles. After that, link_drop_o and pll_rst_o fall, rate_sel_o stays 1 and training at 25G begins.
- R6: While training at 25G, link_up_i=1 gives rate_status_o=10 (linked at 25G) and a one-cycle up_pulse_o.
- R7: If link_up_i stays 0 for UPG_TIMEOUT cycles of 25G training, the controller drives link_drop_o=1, pll_rst_o=1 and rate_sel_o=0 for PLL_WAIT cycles. It then trains at 10G.
- R8: After a fallback, cap_req_o is never raised and rate_sel_o stays 0 until the next reset, whatever cmd_ready_i, cap_valid_i and capability inputs do.
- R9: Loss of link_up_i while linked gives rate_status_o=00 with rate_sel_o unchanged. A loss at 25G restarts the full UPG_TIMEOUT window.
- R10: link_up_i has no effect during a PLL settle period (after reset, during the upgrade drop and during the fallback drop). rate_status_o stays 00 and up_pulse_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Transceiver reports link trained |
| cmd_ready_i | input | 1 | Command channel established |
| cap_valid_i | input | 1 | Capability read completed this cycle |
| peer_cap_i | input | 1 | Peer reports high-rate support |
| local_cap_i | input | 1 | Local side supports high rate |
| rate_sel_o | output | 1 | Rate select to transceiver, 0=10G, 1=25G |
| link_drop_o | output | 1 | Request transceiver to drop the link |
| pll_rst_o | output | 1 | Hold downstream PLL in reset |
| cap_req_o | output | 1 | Request read of peer capability |
| rate_status_o | output | 2 | 00 no link, 01 linked 10G, 10 linked 25G |
| up_pulse_o | output | 1 | One-cycle pulse on each link-up |

## Verification
The bench drives a full upgrade followed by a link loss at 25G and a timeout. A design that failed to restart the timer on the loss would fall back too early, and one that counted off by one would reach the drop a cycle late. Link-up is held high through every settle period, so a controller that listened during a drop would report a link before the PLL was released. After fallback and after a negative capability answer, command-ready and a positive capability are applied again. A controller without a sticky block would raise the capability request again or retry the upgrade. Link loss while the capability request is pending is also tested, to catch a request left hanging.

// File: rtl/lrn_pkg.sv
package lrn_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_TRAIN10 = 3'd1,
    ST_LINK10  = 3'd2,
    ST_RDCAP   = 3'd3,
    ST_DROP    = 3'd4,
    ST_TRAIN25 = 3'd5,
    ST_LINK25  = 3'd6,
    ST_FALLBK  = 3'd7
  } lrn_state_t;

  function automatic logic is_linked(lrn_state_t s);
    return (s == ST_LINK10) || (s == ST_RDCAP) || (s == ST_LINK25);
  endfunction
endpackage

// File: rtl/lrn_rst_sync.sv
module lrn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lrn_timer.sv
module lrn_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | en;
  assign cnt_d  = clr ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == limit);

  // the counter never runs past the active limit: a window is never missed (R7)
  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= limit));
endmodule

// File: rtl/lrn_fsm.sv
module lrn_fsm
  import lrn_pkg::*;
#(
  parameter int CW = 8,
  parameter logic [CW-1:0] WAIT_LIM = 3,
  parameter logic [CW-1:0] TOUT_LIM = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up_i,
  input  logic          cmd_ready_i,
  input  logic          cap_valid_i,
  input  logic          peer_cap_i,
  input  logic          local_cap_i,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic          tmr_en,
  output logic [CW-1:0] tmr_limit,
  output lrn_state_t    state,
  output logic          up_pulse
);
  lrn_state_t state_q, state_d;
  logic       blocked_q, blk_set;
  logic       pulse_d;

  always_comb begin
    state_d = state_q;
    blk_set = 1'b0;
    case (state_q)
      ST_RESET:   if (tmr_done) state_d = ST_TRAIN10;
      ST_TRAIN10: if (link_up_i) state_d = ST_LINK10;
      ST_LINK10: begin
        if (!link_up_i)                     state_d = ST_TRAIN10;
        else if (cmd_ready_i && !blocked_q) state_d = ST_RDCAP;
      end
      ST_RDCAP: begin
        if (!link_up_i) state_d = ST_TRAIN10;
        else if (cap_valid_i) begin
          if (peer_cap_i && local_cap_i) state_d = ST_DROP;
          else begin
            state_d = ST_LINK10;
            blk_set = 1'b1;
          end
        end
      end
      ST_DROP:    if (tmr_done) state_d = ST_TRAIN25;
      ST_TRAIN25: begin
        if (link_up_i)     state_d = ST_LINK25;
        else if (tmr_done) state_d = ST_FALLBK;
      end
      ST_LINK25:  if (!link_up_i) state_d = ST_TRAIN25;
      ST_FALLBK: begin
        blk_set = 1'b1;
        if (tmr_done) state_d = ST_TRAIN10;
      end
      default:    state_d = ST_RESET;
    endcase
  end

  assign pulse_d   = is_linked(state_d) && !is_linked(state_q);
  assign tmr_clr   = (state_d != state_q);
  assign tmr_en    = (state_q == ST_RESET) || (state_q == ST_DROP) ||
                     (state_q == ST_FALLBK) || (state_q == ST_TRAIN25);
  assign tmr_limit = (state_q == ST_TRAIN25) ? TOUT_LIM : WAIT_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET;
      up_pulse  <= 1'b0;
    end else begin
      state_q   <= state_d;
      up_pulse  <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blocked_q <= 1'b0;
    else if (blk_set) blocked_q <= 1'b1;
  end

  assign state = state_q;

  // link-up pulse never lasts longer than one cycle (R2)
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    up_pulse |=> !up_pulse);

  // a rate-change drop is entered only from a positive capability answer (R5)
  assert_drop_from_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP && $past(state_q) != ST_DROP) |->
      ($past(state_q) == ST_RDCAP && $past(peer_cap_i) && $past(local_cap_i)));

  // fallback is entered only out of 25G training (R7)
  assert_fallback_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FALLBK && $past(state_q) != ST_FALLBK) |->
      ($past(state_q) == ST_TRAIN25));

  // once blocked, no capability read and no upgrade until reset (R8)
  assert_no_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |=> (state_q != ST_RDCAP) && (state_q != ST_DROP));
endmodule

// File: rtl/lrn_outdec.sv
module lrn_outdec
  import lrn_pkg::*;
(
  input  lrn_state_t state,
  output logic       rate_sel,
  output logic       link_drop,
  output logic       pll_rst,
  output logic       cap_req,
  output logic [1:0] rate_status
);
  always_comb begin
    rate_sel    = 1'b0;
    link_drop   = 1'b0;
    pll_rst     = 1'b0;
    cap_req     = 1'b0;
    rate_status = 2'b00;
    case (state)
      ST_RESET:   pll_rst = 1'b1;
      ST_LINK10:  rate_status = 2'b01;
      ST_RDCAP: begin
        cap_req     = 1'b1;
        rate_status = 2'b01;
      end
      ST_DROP: begin
        rate_sel  = 1'b1;
        link_drop = 1'b1;
        pll_rst   = 1'b1;
      end
      ST_TRAIN25: rate_sel = 1'b1;
      ST_LINK25: begin
        rate_sel    = 1'b1;
        rate_status = 2'b10;
      end
      ST_FALLBK: begin
        link_drop = 1'b1;
        pll_rst   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/link_rate_ctrl.sv
module link_rate_ctrl
  import lrn_pkg::*;
#(
  parameter int PLL_WAIT    = 16,
  parameter int UPG_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up_i,
  input  logic       cmd_ready_i,
  input  logic       cap_valid_i,
  input  logic       peer_cap_i,
  input  logic       local_cap_i,
  output logic       rate_sel_o,
  output logic       link_drop_o,
  output logic       pll_rst_o,
  output logic       cap_req_o,
  output logic [1:0] rate_status_o,
  output logic       up_pulse_o
);
  localparam int MAXC = (PLL_WAIT > UPG_TIMEOUT) ? PLL_WAIT : UPG_TIMEOUT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAIT_LIM = CW'(PLL_WAIT - 1);
  localparam logic [CW-1:0] TOUT_LIM = CW'(UPG_TIMEOUT - 1);

  logic          rst_s;
  logic          tmr_clr, tmr_en, tmr_done;
  logic [CW-1:0] tmr_limit;
  lrn_state_t    state;

  lrn_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  lrn_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_s), .clr(tmr_clr), .en(tmr_en),
    .limit(tmr_limit), .done(tmr_done)
  );

  lrn_fsm #(.CW(CW), .WAIT_LIM(WAIT_LIM), .TOUT_LIM(TOUT_LIM)) u_fsm (
    .clk(clk), .rst_n(rst_s),
    .link_up_i(link_up_i), .cmd_ready_i(cmd_ready_i),
    .cap_valid_i(cap_valid_i), .peer_cap_i(peer_cap_i),
    .local_cap_i(local_cap_i), .tmr_done(tmr_done),
    .tmr_clr(tmr_clr), .tmr_en(tmr_en), .tmr_limit(tmr_limit),
    .state(state), .up_pulse(up_pulse_o)
  );

  lrn_outdec u_dec (
    .state(state), .rate_sel(rate_sel_o), .link_drop(link_drop_o),
    .pll_rst(pll_rst_o), .cap_req(cap_req_o), .rate_status(rate_status_o)
  );
endmodule

// File: tb/tb_link_rate_ctrl.sv
`timescale 1ns/1ps
module tb_link_rate_ctrl;
  localparam int PW = 4;
  localparam int TO = 10;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic link_up, cmd_ready, cap_valid, peer_cap, local_cap;
  logic rate_sel, link_drop, pll_rst, cap_req, up_pulse;
  logic [1:0] rate_status;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_rate_ctrl #(.PLL_WAIT(PW), .UPG_TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .cmd_ready_i(cmd_ready),
    .cap_valid_i(cap_valid), .peer_cap_i(peer_cap), .local_cap_i(local_cap),
    .rate_sel_o(rate_sel), .link_drop_o(link_drop), .pll_rst_o(pll_rst),
    .cap_req_o(cap_req), .rate_status_o(rate_status), .up_pulse_o(up_pulse)
  );

  // {reps[7:0], in{link,cmd,capv,peer,local}[4:0],
  //  exp{rate,drop,pll,capreq,status[1:0],pulse}[6:0], req[3:0]}
  localparam logic [23:0] VECS [0:NV-1] = '{
    {8'd5, 5'b10000, 7'b0010000, 4'd10}, // R10 link-up ignored in reset settle
    {8'd1, 5'b00000, 7'b0000000, 4'd1},  // R1 PLL released, training 10G
    {8'd1, 5'b10000, 7'b0000011, 4'd2},  // R2 linked 10G with pulse
    {8'd1, 5'b10000, 7'b0000010, 4'd2},  // R2 pulse one cycle
    {8'd1, 5'b00000, 7'b0000000, 4'd9},  // R9 link loss at 10G
    {8'd1, 5'b10000, 7'b0000011, 4'd2},  // R2 relink
    {8'd1, 5'b11000, 7'b0001010, 4'd3},  // R3 capability request
    {8'd1, 5'b11111, 7'b1110000, 4'd5},  // R5 drop for upgrade
    {8'd3, 5'b10000, 7'b1110000, 4'd10}, // R10 link-up ignored in drop
    {8'd1, 5'b00000, 7'b1000000, 4'd5},  // R5 training 25G
    {8'd1, 5'b10000, 7'b1000101, 4'd6},  // R6 linked 25G
    {8'd1, 5'b00000, 7'b1000000, 4'd9},  // R9 loss at 25G
    {8'd9, 5'b00000, 7'b1000000, 4'd7},  // R7 timeout window not yet over
    {8'd1, 5'b00000, 7'b0110000, 4'd7},  // R7 fallback drop
    {8'd3, 5'b10000, 7'b0110000, 4'd10}, // R10 link-up ignored in fallback
    {8'd1, 5'b00000, 7'b0000000, 4'd7},  // R7 training 10G again
    {8'd1, 5'b11000, 7'b0000011, 4'd2},  // R2 linked 10G
    {8'd5, 5'b11111, 7'b0000010, 4'd8}   // R8 no further upgrade
  };

  task automatic step(input int reps, input logic [4:0] in,
                      input logic [6:0] exp, input int req);
    logic [6:0] act;
    {link_up, cmd_ready, cap_valid, peer_cap, local_cap} = in;
    for (int r = 0; r < reps; r++) @(negedge clk);
    act = {rate_sel, link_drop, pll_rst, cap_req, rate_status, up_pulse};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    {link_up, cmd_ready, cap_valid, peer_cap, local_cap} = 5'b0;
    rst_n = 1'b0;
    #1;
    step(0, 5'b00000, 7'b0010000, 1); // R1 reset values
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {link_up, cmd_ready, cap_valid, peer_cap, local_cap} = 5'b0;
    repeat (3) @(negedge clk);
    step(0, 5'b00000, 7'b0010000, 1); // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      step(int'(VECS[i][23:16]), VECS[i][15:11], VECS[i][10:4],
           int'(VECS[i][3:0]));

    // R4: local side lacks high-rate support
    do_reset();
    step(6, 5'b00000, 7'b0000000, 1);
    step(1, 5'b11000, 7'b0000011, 2);
    step(1, 5'b11000, 7'b0001010, 3);
    step(1, 5'b11110, 7'b0000010, 4);
    step(4, 5'b11000, 7'b0000010, 4);

    // R3: link lost while request pending, then R4 peer lacks support
    do_reset();
    step(6, 5'b00000, 7'b0000000, 1);
    step(1, 5'b10000, 7'b0000011, 2);
    step(1, 5'b11000, 7'b0001010, 3);
    step(1, 5'b01000, 7'b0000000, 3);
    step(1, 5'b11000, 7'b0000011, 2);
    step(1, 5'b11000, 7'b0001010, 3);
    step(1, 5'b11101, 7'b0000010, 4);
    step(3, 5'b11111, 7'b0000010, 4);

    // R1: asynchronous reset in the middle of operation
    do_reset();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule